// File: doc/BRIEF.md
# Masked Pixel Write Datapath

This block sits on the write side of a 32-bit graphics DRAM and turns one write request into per-column data words with per-bit write enables. It holds two persistent registers, loaded from the data bus by strobes that a command decoder upstream produces. The plane mask selects which bit planes may change. The color register holds the fill value for block writes. Each 32-bit word is four 8-bit pixels, and a per-pixel byte mask that arrives with the data removes whole pixels from the write.

A normal write sends the data bus to the one column picked by the column address. A block write sends the color register to the eight columns of an aligned group, all at once. In a block write the data bus carries no data. Bit `b*8+c` of the bus enables pixel `b` of column `c` within the group. The three masks are combined with AND, and the result goes to a storage array outside the block one clock after the request.

Top module: `pixel_write_path`

## Requirements
- R1: After reset, `wr_valid` and every `wr_bit_en` bit are 0, the plane mask holds all ones and the color register holds zero.
- R2: A cycle with `plane_load` high stores `data_in` in the plane mask, and a cycle with `color_load` high stores `data_in` in the color register. A load drives no output (`wr_valid` stays 0 the next cycle), and the new value applies from the next cycle on.
- R3: A normal write (`wr_req` high, `blk_req` low) sets `wr_valid` one cycle later. `wr_col_base` is then `col_addr` with its low 3 bits cleared. Only lane `col_addr[2:0]` (bits `c*32 +: 32` of the lane buses) may have enables set, and every lane of `wr_data` carries `data_in`.
- R4: `byte_mask[b]` = 1 (masked) clears enable bits `b*8 .. b*8+7` in every lane for the write of that same cycle. There is no latency between the mask and its data.
- R5: When `wpb_en` is 1, enable bit `i` can be set only where plane mask bit `i` is 1. When `wpb_en` is 0, the plane mask has no effect.
- R6: A block write (`blk_req` high) sets `wr_valid` one cycle later, and all 8 lanes of `wr_data` carry the color register. Lane `c`, pixel `b` is enabled only if `data_in[b*8+c]` is 1 (0 = column masked).
- R7: In a block write, enable bit `i` of lane `c` is the AND of the pixel mask bit, the byte mask (not masked), and the plane mask (when `wpb_en` is 1).
- R8: A block write ignores `col_addr[2:0]`, and `wr_col_base` always has its low 3 bits at 0.
- R9: If `blk_req` and `wr_req` are both high, the block write wins. With neither high, `wr_valid` and all enables are 0.
- R10: The plane mask and color register keep their values across any number of writes until they are loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| plane_load | input | 1 | Load plane mask from data_in |
| color_load | input | 1 | Load color register from data_in |
| wr_req | input | 1 | Normal write strobe |
| blk_req | input | 1 | Eight-column block write strobe |
| wpb_en | input | 1 | Write-per-bit enabled for the addressed bank |
| col_addr | input | 9 | Column address |
| data_in | input | 32 | Write data, or pixel/column mask in a block write |
| byte_mask | input | 4 | Per-pixel mask, 1 = masked |
| wr_valid | output | 1 | Result lanes valid |
| wr_col_base | output | 9 | Aligned base column of the 8-lane group |
| wr_data | output | 256 | Eight 32-bit lane words, lane c at bits c*32 +: 32 |
| wr_bit_en | output | 256 | Per-bit write enables, same layout |

## Verification
The hardest case is a block write in which all three masks are active together, each with a different irregular pattern. Only then can a swapped pixel index or a dropped term in the AND be seen. Reaching it takes a preloaded plane mask with set and clear bits in every byte, then a block request whose data bus is a scattered pixel pattern, paired with a partial byte mask, `wpb_en` set and an unaligned column address. The scoreboard restates the enable rule bit by bit for all 256 outputs.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_BLOCK = 2'd2
  } op_e;
endpackage

// File: rtl/pwp_mask_regs.sv
module pwp_mask_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_plane,
  input  logic          ld_color,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] plane_q,
  output logic [DW-1:0] color_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plane_q <= '1;
      color_q <= '0;
    end else begin
      if (ld_plane) plane_q <= din;
      if (ld_color) color_q <= din;
    end
  end

  // R2
  plane_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_plane |=> plane_q == $past(din));
  // R2
  color_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_color |=> color_q == $past(din));
  // R10
  plane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_plane |=> $stable(plane_q));
endmodule

// File: rtl/pwp_lane.sv
module pwp_lane
  import pwp_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int PIXELS = 4,
  parameter int LANE   = 0,
  localparam int DW    = PIX_W * PIXELS
) (
  input  op_e               op,
  input  logic              col_hit,
  input  logic [DW-1:0]     din,
  input  logic [DW-1:0]     color,
  input  logic [DW-1:0]     plane_eff,
  input  logic [PIXELS-1:0] byte_mask,
  output logic [DW-1:0]     lane_data,
  output logic [DW-1:0]     lane_en
);
  // Widen one flag per pixel into a per-bit vector.
  function automatic logic [DW-1:0] spread_pixels(input logic [PIXELS-1:0] keep);
    logic [DW-1:0] r;
    for (int b = 0; b < PIXELS; b++) r[b*PIX_W +: PIX_W] = {PIX_W{keep[b]}};
    return r;
  endfunction

  // In a block write, bit LANE of each pixel byte selects this column.
  function automatic logic [PIXELS-1:0] pick_columns(input logic [DW-1:0] bus);
    logic [PIXELS-1:0] r;
    for (int b = 0; b < PIXELS; b++) r[b] = bus[b*PIX_W + LANE];
    return r;
  endfunction

  logic [DW-1:0] byte_keep;
  logic [DW-1:0] col_keep;

  assign byte_keep = spread_pixels(~byte_mask);

  always_comb begin
    case (op)
      OP_WRITE: begin
        lane_data = din;
        col_keep  = {DW{col_hit}};
      end
      OP_BLOCK: begin
        lane_data = color;
        col_keep  = spread_pixels(pick_columns(din));
      end
      default: begin
        lane_data = '0;
        col_keep  = '0;
      end
    endcase
    lane_en = byte_keep & plane_eff & col_keep;
  end

  // R5
  always_comb plane_gate_chk: assert ((lane_en & ~plane_eff) == '0);
  // R4
  always_comb begin
    for (int b = 0; b < PIXELS; b++)
      byte_gate_chk: assert (!(byte_mask[b] && (|lane_en[b*PIX_W +: PIX_W])));
  end
endmodule

// File: rtl/pixel_write_path.sv
module pixel_write_path
  import pwp_pkg::*;
#(
  parameter  int PIX_W    = 8,
  parameter  int PIXELS   = 4,
  parameter  int BLK_COLS = 8,   // must not exceed PIX_W
  parameter  int COL_W    = 9,
  localparam int DW       = PIX_W * PIXELS,
  localparam int LANE_W   = $clog2(BLK_COLS),
  localparam int OUT_W    = BLK_COLS * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              plane_load,
  input  logic              color_load,
  input  logic              wr_req,
  input  logic              blk_req,
  input  logic              wpb_en,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [DW-1:0]     data_in,
  input  logic [PIXELS-1:0] byte_mask,
  output logic              wr_valid,
  output logic [COL_W-1:0]  wr_col_base,
  output logic [OUT_W-1:0]  wr_data,
  output logic [OUT_W-1:0]  wr_bit_en
);
  op_e           op_now, op_q;
  logic [DW-1:0] plane_q, color_q, plane_eff;
  logic [OUT_W-1:0] data_w, en_w;
  logic [BLK_COLS-1:0] lane_hit;

  assign op_now    = blk_req ? OP_BLOCK : (wr_req ? OP_WRITE : OP_IDLE);
  assign plane_eff = wpb_en ? plane_q : '1;

  pwp_mask_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_plane(plane_load), .ld_color(color_load),
    .din(data_in), .plane_q(plane_q), .color_q(color_q)
  );

  for (genvar c = 0; c < BLK_COLS; c++) begin : g_lane
    logic hit;
    assign hit = (col_addr[LANE_W-1:0] == LANE_W'(c));
    pwp_lane #(.PIX_W(PIX_W), .PIXELS(PIXELS), .LANE(c)) u_lane (
      .op(op_now), .col_hit(hit), .din(data_in), .color(color_q),
      .plane_eff(plane_eff), .byte_mask(byte_mask),
      .lane_data(data_w[c*DW +: DW]), .lane_en(en_w[c*DW +: DW])
    );
    assign lane_hit[c] = |wr_bit_en[c*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q        <= OP_IDLE;
      wr_valid    <= 1'b0;
      wr_col_base <= '0;
      wr_data     <= '0;
      wr_bit_en   <= '0;
    end else begin
      op_q        <= op_now;
      wr_valid    <= (op_now != OP_IDLE);
      wr_col_base <= {col_addr[COL_W-1:LANE_W], {LANE_W{1'b0}}};
      wr_data     <= data_w;
      wr_bit_en   <= en_w;
    end
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> wr_bit_en == '0);
  // R3
  single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_WRITE) |-> $onehot0(lane_hit));
  // R8
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_col_base[LANE_W-1:0] == '0);
  // R6
  block_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_req |=> wr_data == {BLK_COLS{$past(color_q)}});
endmodule

// File: tb/test_pixel_write_path.sv
module test_pixel_write_path;
  localparam int DW = 32, COLS = 8, CW = 9, OW = 256;

  logic clk = 0, rst_n = 0;
  logic plane_load = 0, color_load = 0, wr_req = 0, blk_req = 0, wpb_en = 0;
  logic [CW-1:0] col_addr = '0;
  logic [DW-1:0] data_in = '0;
  logic [3:0] byte_mask = '0;
  logic wr_valid;
  logic [CW-1:0] wr_col_base;
  logic [OW-1:0] wr_data, wr_bit_en;

  always #2.5 clk = ~clk;

  pixel_write_path i_pixel_write_path (
    .clk(clk), .rst_n(rst_n), .plane_load(plane_load), .color_load(color_load),
    .wr_req(wr_req), .blk_req(blk_req), .wpb_en(wpb_en), .col_addr(col_addr),
    .data_in(data_in), .byte_mask(byte_mask), .wr_valid(wr_valid),
    .wr_col_base(wr_col_base), .wr_data(wr_data), .wr_bit_en(wr_bit_en)
  );

  typedef struct {
    string tag;
    logic valid;
    logic [CW-1:0] base;
    logic [OW-1:0] data;
    logic [OW-1:0] en;
  } item_t;

  item_t sb[$];
  int errors = 0, checks = 0;
  logic [DW-1:0] m_plane = '1, m_color = '0;
  bit done = 0;

  task automatic check(string tag, bit ok, string what, logic [OW-1:0] act, logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: set inputs, work out the result the requirements demand, queue it.
  task automatic drive(string tag, bit pl, bit cl, bit wr, bit blk, bit wpb,
                       logic [CW-1:0] col, logic [DW-1:0] d, logic [3:0] bm);
    item_t it;
    @(negedge clk);
    plane_load = pl; color_load = cl; wr_req = wr; blk_req = blk;
    wpb_en = wpb; col_addr = col; data_in = d; byte_mask = bm;
    it.tag = tag;
    it.valid = wr | blk;
    it.base = col & ~CW'(7);
    it.data = '0;
    it.en = '0;
    for (int c = 0; c < COLS; c++) begin
      it.data[c*DW +: DW] = blk ? m_color : d;
      for (int i = 0; i < DW; i++) begin
        bit pix_ok, plane_ok, col_ok;
        pix_ok   = !bm[i/8];
        plane_ok = !wpb || m_plane[i];
        col_ok   = blk ? d[(i/8)*8 + c] : (wr && col[2:0] == 3'(c));
        it.en[c*DW + i] = it.valid && pix_ok && plane_ok && col_ok;
      end
    end
    sb.push_back(it);
    if (pl) m_plane = d;
    if (cl) m_color = d;
  endtask

  task automatic idle(string tag);
    drive(tag, 0, 0, 0, 0, 0, '0, '0, '0);
  endtask

  // Monitor: pop one expected item per clock and compare.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t e;
        e = sb.pop_front();
        check(e.tag, wr_valid == e.valid, "valid", OW'(wr_valid), OW'(e.valid));
        check(e.tag, wr_bit_en == e.en, "bit_en", wr_bit_en, e.en);
        if (e.valid) begin
          check(e.tag, wr_col_base == e.base, "col_base", OW'(wr_col_base), OW'(e.base));
          check(e.tag, wr_data == e.data, "data", wr_data, e.data);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state at the ports
    check("R1", wr_valid == 1'b0, "reset valid", OW'(wr_valid), '0);
    check("R1", wr_bit_en == '0, "reset bit_en", wr_bit_en, '0);
    @(negedge clk);
    rst_n = 1;
    // R1: reset color zero, reset plane all ones
    drive("R1", 0, 0, 0, 1, 1, 9'd40, 32'hFFFF_FFFF, 4'b0000);
    // R2 loads produce no output
    drive("R2", 0, 1, 0, 0, 0, 9'd3, 32'hA5C3_0F1E, 4'b0000);
    drive("R2", 1, 0, 0, 0, 0, 9'd3, 32'h7EB7_FD76, 4'b0000);
    // R3 normal write to several lanes
    drive("R3", 0, 0, 1, 0, 0, 9'd5,   32'h1234_5678, 4'b0000);
    drive("R3", 0, 0, 1, 0, 0, 9'd256, 32'hDEAD_BEEF, 4'b0000);
    drive("R3", 0, 0, 1, 0, 0, 9'd511, 32'hCAFE_F00D, 4'b0000);
    // R4 byte masks, same cycle as data
    drive("R4", 0, 0, 1, 0, 0, 9'd2, 32'hFFFF_FFFF, 4'b0101);
    drive("R4", 0, 0, 1, 0, 0, 9'd6, 32'hFFFF_FFFF, 4'b1111);
    // R5 plane mask on, then off
    drive("R5", 0, 0, 1, 0, 1, 9'd1, 32'h0F0F_0F0F, 4'b0000);
    drive("R5", 0, 0, 1, 0, 0, 9'd1, 32'h0F0F_0F0F, 4'b0000);
    // R6 block fill with pixel masks
    drive("R6", 0, 0, 0, 1, 0, 9'd16, 32'hFF01_80AA, 4'b0000);
    // R7 all three masks together
    drive("R7", 0, 0, 0, 1, 1, 9'd64, 32'h5AC3_9617, 4'b0010);
    // R8 unaligned block column
    drive("R8", 0, 0, 0, 1, 1, 9'd13, 32'h3C3C_81E7, 4'b1000);
    // R9 both strobes, then idle
    drive("R9", 0, 0, 1, 1, 0, 9'd21, 32'h0102_0408, 4'b0000);
    idle("R9");
    // R10 plane persists over several writes, then reload
    drive("R10", 0, 0, 1, 0, 1, 9'd4,  32'hFFFF_FFFF, 4'b0000);
    drive("R10", 0, 0, 1, 0, 1, 9'd99, 32'hFFFF_FFFF, 4'b0000);
    drive("R10", 1, 0, 0, 0, 0, 9'd0,  32'h00FF_F00F, 4'b0000);
    drive("R10", 0, 0, 0, 1, 1, 9'd32, 32'hFFFF_FFFF, 4'b0000);
    drive("R10", 0, 0, 1, 0, 1, 9'd7,  32'h8765_4321, 4'b0100);
    idle("R9");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule